// File: doc/BRIEF.md
# UART transmitter with pin handoff

The block is the transmit half of an asynchronous serial port. It serialises bytes from a one-deep data register through a shift register and paces each bit with an externally supplied oversampling tick. Software controls it through one byte-wide control register and sees two status flags: "ready for data" and "everything sent". One interrupt line merges four enable/flag pairs. Two of those flags come from a receiver that lives outside this block.

Besides data frames, the transmitter can send two special characters: an all-high idle character and an all-low break character. Dropping and then raising the transmit enable while a frame is on the line queues one idle character behind that frame. Dropping the enable never cuts the line short. The transmitter keeps ownership of the pin until every queued character has left. The block also reports pin ownership and direction for three cases: normal use, internal loopback (the pin is released) and single-wire mode (the direction follows a control input).

Top module: `sertx_core`

## Requirements
- R1: The control register resets to 0x00, reads back the last written byte at any time, and has this bit layout: bit 7 ready-irq enable, bit 6 done-irq enable, bit 5 receive-full-irq enable, bit 4 receive-idle-irq enable, bit 3 transmit enable, bit 2 receive enable, bit 1 receiver wake-up, bit 0 send-break.
- R2: `irq` is high exactly when at least one of these pairs is high: (bit 7, `tdre`), (bit 6, `tc`), (bit 5, `rx_full`), (bit 4, `rx_idle`). With an enable at 0, its flag has no effect on `irq`.
- R3: A data frame is one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit lasts 16 `baud_tick` pulses. `txd` is high when no character is being sent.
- R4: `tdre` and `tc` reset to 1. A data-register write clears both. `tdre` sets when the byte moves into the shifter. `tc` is 1 only when the shifter, the data register and the idle and break queues are all empty.
- R5: While transmit enable is 0 and no drain is in progress, a written byte is held: `tdre` stays 0, `txd` stays high and `tx_own` stays 0.
- R6: Writing transmit enable 0 and then 1 while a character is being shifted queues one idle character (10 bit-times high). It is sent after the current character and ahead of any pending data byte.
- R7: After transmit enable is written to 0, `tx_own` stays 1 until every queued data, idle and break character has finished. `tx_own` drops one clock after `tc` returns to 1.
- R8: A control write with bit 0 set queues one break character (10 bit-times low). When several characters wait, the shifter takes an idle character first, then a break character, then a data byte.
- R9: With `loop_en`=1 and `rx_src`=0, `tx_own` and `tx_oe` are 0 even while transmit enable is 1.
- R10: With `loop_en`=1 and `rx_src`=1 (single-wire), `tx_own` follows transmit enable and `tx_oe` equals `wire_dir`. Outside loop mode, `tx_oe` equals `tx_own`.
- R11: `rx_own` equals control bit 2. When that bit is 0, the receive pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| loop_en | input | 1 | Loop mode select |
| rx_src | input | 1 | Receiver source select in loop mode (1 = single-wire) |
| wire_dir | input | 1 | Single-wire direction, 1 = output |
| rx_full | input | 1 | Receiver data-full flag |
| rx_idle | input | 1 | Receiver idle-line flag |
| txd | output | 1 | Serial transmit line |
| tx_own | output | 1 | Transmitter controls the transmit pin |
| tx_oe | output | 1 | Transmit pin driven as an output |
| rx_own | output | 1 | Receiver controls the receive pin |
| tdre | output | 1 | Data register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong character queue or wrong priority shows on `txd` within one frame time (160 ticks): a missing idle character removes a 10-bit gap, and a misordered break swaps a low frame with a data frame. A drain flag that clears too early drops `tx_own` while the shifter is still busy, which is visible in the middle of the last frame. A flag error in `tdre` or `tc` appears on the very next clock after a data write or after the final stop bit, and `irq` carries the error one step further because it is gated by those same flags.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int STOP_W  = 1;
  localparam int FRAME_W = DATA_W + STOP_W + 1;

  typedef enum logic [1:0] {CH_DATA = 2'd0, CH_IDLE = 2'd1, CH_BREAK = 2'd2} char_kind_e;

  typedef struct packed {
    logic rdy_ie;
    logic done_ie;
    logic rxf_ie;
    logic rxi_ie;
    logic tx_en;
    logic rx_en;
    logic rx_wake;
    logic brk_req;
  } ctl_reg_t;

  // Bit pattern shifted out LSB first for each kind of character.
  function automatic logic [FRAME_W-1:0] frame_bits(char_kind_e k, logic [DATA_W-1:0] d);
    case (k)
      CH_IDLE:  frame_bits = '1;
      CH_BREAK: frame_bits = '0;
      default:  frame_bits = {{STOP_W{1'b1}}, d, 1'b0};
    endcase
  endfunction

  function automatic logic irq_merge(ctl_reg_t c, logic rdy, logic done, logic rxf, logic rxi);
    irq_merge = (c.rdy_ie & rdy) | (c.done_ie & done) | (c.rxf_ie & rxf) | (c.rxi_ie & rxi);
  endfunction
endpackage

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               txd_bit
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic [SUB_W-1:0]   sub;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] shreg;

  wire bit_end  = busy & tick & (sub == SUB_W'(OVS - 1));
  wire last_bit = (bitn == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '1;
    end else if (load && !busy) begin
      busy  <= 1'b1;
      sub   <= '0;
      bitn  <= '0;
      shreg <= frame;
    end else if (busy && tick) begin
      if (bit_end) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        if (last_bit) busy <= 1'b0;
        else          bitn <= bitn + BIT_W'(1);
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  assign txd_bit = busy ? shreg[0] : 1'b1;

  a_r3_hold_within_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(shreg));
  a_r3_bit_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitn <= BIT_W'(FRAME_W - 1)));
endmodule

// File: rtl/sertx_ctl.sv
`timescale 1ns/1ps
module sertx_ctl
  import sertx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [7:0]         ctl_wdata,
  input  logic               dat_wr,
  input  logic [DATA_W-1:0]  dat_wdata,
  input  logic               busy,
  input  logic               rx_full,
  input  logic               rx_idle,
  output ctl_reg_t           ctl,
  output logic               tdre,
  output logic               tc,
  output logic               irq,
  output logic               active,
  output logic               load,
  output logic [FRAME_W-1:0] load_frame
);
  ctl_reg_t          ctl_new;
  logic [DATA_W-1:0] dreg;
  logic              idle_pend, brk_pend, draining;
  char_kind_e        kind;

  assign ctl_new = ctl_reg_t'(ctl_wdata);

  wire te_set      = ctl_wr & ctl_new.tx_en & ~ctl.tx_en;
  wire te_clr      = ctl_wr & ~ctl_new.tx_en & ctl.tx_en;
  wire want        = idle_pend | brk_pend | ~tdre;
  wire outstanding = busy | want;

  assign active = ctl.tx_en | draining;
  assign load   = active & ~busy & want;

  always_comb begin
    if (idle_pend)     kind = CH_IDLE;
    else if (brk_pend) kind = CH_BREAK;
    else               kind = CH_DATA;
  end

  assign load_frame = frame_bits(kind, dreg);

  wire take_idle = load & (kind == CH_IDLE);
  wire take_brk  = load & (kind == CH_BREAK);
  wire take_data = load & (kind == CH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      dreg      <= '0;
      tdre      <= 1'b1;
      idle_pend <= 1'b0;
      brk_pend  <= 1'b0;
      draining  <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= ctl_new;
      if (dat_wr) dreg <= dat_wdata;
      if (dat_wr)         tdre <= 1'b0;
      else if (take_data) tdre <= 1'b1;
      if (te_set && busy)  idle_pend <= 1'b1;
      else if (take_idle)  idle_pend <= 1'b0;
      if (ctl_wr && ctl_new.brk_req) brk_pend <= 1'b1;
      else if (take_brk)             brk_pend <= 1'b0;
      draining <= outstanding & (te_clr | draining);
    end
  end

  assign tc  = ~outstanding;
  assign irq = irq_merge(ctl, tdre, tc, rx_full, rx_idle);

  a_r4_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> !tdre);
  a_r6_idle_leaves_first: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_pend && load) |=> !idle_pend);
endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core
  import sertx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  input  logic       loop_en,
  input  logic       rx_src,
  input  logic       wire_dir,
  input  logic       rx_full,
  input  logic       rx_idle,
  output logic       txd,
  output logic       tx_own,
  output logic       tx_oe,
  output logic       rx_own,
  output logic       tdre,
  output logic       tc,
  output logic       irq
);
  ctl_reg_t           ctl;
  logic               busy, active, load;
  logic [FRAME_W-1:0] load_frame;

  sertx_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .busy(busy), .rx_full(rx_full), .rx_idle(rx_idle),
    .ctl(ctl), .tdre(tdre), .tc(tc), .irq(irq),
    .active(active), .load(load), .load_frame(load_frame)
  );

  sertx_shift #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .load(load), .frame(load_frame),
    .busy(busy), .txd_bit(txd)
  );

  wire pin_released = loop_en & ~rx_src;
  wire single_wire  = loop_en & rx_src;

  assign ctl_rdata = ctl;
  assign tx_own    = active & ~pin_released;
  assign tx_oe     = tx_own & (single_wire ? wire_dir : 1'b1);
  assign rx_own    = ctl.rx_en;

  a_r7_pin_kept_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !loop_en) |-> tx_own);
  a_r5_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !busy) |=> !busy);
  a_r4_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> txd);
endmodule

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic loop_en = 1'b0, rx_src = 1'b0, wire_dir = 1'b0;
  logic rx_full = 1'b0, rx_idle = 1'b0;
  logic [7:0] ctl_rdata;
  logic txd, tx_own, tx_oe, rx_own, tdre, tc, irq;

  int checks = 0;
  int errors = 0;
  int tick_total = 0;

  typedef struct { int kind; logic [7:0] d; } exp_t;  // kind 0 data, 1 idle, 2 break
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;
  always @(posedge clk) if (baud_tick) tick_total <= tick_total + 1;

  sertx_core uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .loop_en(loop_en), .rx_src(rx_src), .wire_dir(wire_dir),
    .rx_full(rx_full), .rx_idle(rx_idle),
    .txd(txd), .tx_own(tx_own), .tx_oe(tx_oe), .rx_own(rx_own),
    .tdre(tdre), .tc(tc), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] v);
    exp_t e;
    e.kind = 0; e.d = v; exp_q.push_back(e);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic expect_kind(input int k);
    exp_t e;
    e.kind = k; e.d = '0; exp_q.push_back(e);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !tdre; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !(tc && exp_q.size() == 0); i++) @(negedge clk);
    chk(tc && exp_q.size() == 0, "R4", "all queued characters sent", exp_q.size(), 0);
  endtask

  // Monitor: decodes frames on txd and compares them with the scoreboard queue.
  initial begin
    int last_end;
    last_end = 0;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        int t0;
        logic [9:0] bits;
        exp_t e;
        t0 = tick_total;
        for (int i = 0; i < 10; i++) begin
          while (tick_total < t0 + 8 + 16 * i) @(negedge clk);
          bits[i] = txd;
        end
        if (exp_q.size() > 0 && exp_q[0].kind == 1) begin
          chk(t0 - last_end >= 150, "R6", "idle gap in ticks", t0 - last_end, 160);
          void'(exp_q.pop_front());
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected frame", int'(bits), 0);
        end else begin
          e = exp_q.pop_front();
          if (e.kind == 2)
            chk(bits == 10'h000, "R8", "break frame bits", int'(bits), 0);
          else
            chk(bits == {1'b1, e.d, 1'b0}, "R3", "data frame bits", int'(bits), int'({1'b1, e.d, 1'b0}));
        end
        while (tick_total < t0 + 160) @(negedge clk);
        last_end = tick_total;
      end
    end
  end

  initial begin
    #800000;
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(ctl_rdata == 8'h00, "R1", "ctl reset", ctl_rdata, 0);
    chk(tdre && tc, "R4", "flags reset", {tdre, tc}, 3);
    chk(txd == 1'b1 && tx_own == 1'b0, "R5", "pin at reset", {txd, tx_own}, 2);
    chk(rx_own == 1'b0, "R11", "rx pin at reset", rx_own, 0);
    chk(irq == 1'b0, "R2", "irq at reset", irq, 0);

    // R1 readback, R11 receive enable, R2 ready-irq gating
    wr_ctl(8'hA6);
    chk(ctl_rdata == 8'hA6, "R1", "readback", ctl_rdata, 8'hA6);
    chk(rx_own == 1'b1, "R11", "rx pin owned", rx_own, 1);
    chk(irq == 1'b1, "R2", "ready irq", irq, 1);
    rx_full = 1'b1; rx_idle = 1'b1;
    wr_ctl(8'h00);
    chk(irq == 1'b0, "R2", "all enables off", irq, 0);
    chk(rx_own == 1'b0, "R11", "rx pin released", rx_own, 0);
    wr_ctl(8'h20);
    chk(irq == 1'b1, "R2", "rx full irq", irq, 1);
    rx_full = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R2", "rx full flag low", irq, 0);
    wr_ctl(8'h10);
    chk(irq == 1'b1, "R2", "rx idle irq", irq, 1);
    rx_idle = 1'b0;
    wr_ctl(8'h40);
    chk(irq == 1'b1, "R2", "done irq", irq, 1);
    wr_ctl(8'h00);

    // R5: held while disabled, R4 flags clear on write
    send(8'h5A);
    chk(tdre == 1'b0 && tc == 1'b0, "R4", "write clears flags", {tdre, tc}, 0);
    repeat (400) @(negedge clk);
    chk(tdre == 1'b0, "R5", "byte held", tdre, 0);
    chk(txd == 1'b1 && tx_own == 1'b0, "R5", "line idle, pin free", {txd, tx_own}, 2);
    wr_ctl(8'h08);
    wait_ready();
    chk(tdre == 1'b1 && tc == 1'b0, "R4", "ready set on load", {tdre, tc}, 2);
    chk(tx_own == 1'b1 && tx_oe == 1'b1, "R10", "normal pin output", {tx_own, tx_oe}, 3);
    wait_done();

    // R3: several patterns back to back
    send(8'hA5); wait_ready();
    send(8'h01); wait_ready();
    send(8'hFF);
    wait_done();
    send(8'h00);
    wait_done();

    // R6: enable toggled mid-frame queues one idle character before pending data
    send(8'h3C); wait_ready();
    expect_kind(1);
    send(8'hC3);
    wr_ctl(8'h00);
    wr_ctl(8'h08);
    wait_done();

    // R7: pin kept until queued output has drained
    send(8'h11); wait_ready();
    send(8'h22);
    wr_ctl(8'h00);
    chk(tx_own == 1'b1, "R7", "pin kept after disable", tx_own, 1);
    repeat (500) @(negedge clk);
    chk(tx_own == 1'b1, "R7", "pin kept during last frame", tx_own, 1);
    wait_done();
    @(negedge clk);
    chk(tx_own == 1'b0, "R7", "pin released after drain", tx_own, 0);

    // R8: break alone, then priority break before pending data
    wr_ctl(8'h08);
    expect_kind(2);
    wr_ctl(8'h09);
    wr_ctl(8'h08);
    chk(tc == 1'b0, "R8", "break queued", tc, 0);
    wait_done();
    repeat (40) @(negedge clk);
    send(8'h44); wait_ready();
    expect_kind(2);
    send(8'h55);
    wr_ctl(8'h09);
    wr_ctl(8'h08);
    wait_done();

    // R9 / R10: loop and single-wire pin control
    loop_en = 1'b1; rx_src = 1'b0;
    @(negedge clk);
    chk(tx_own == 1'b0 && tx_oe == 1'b0, "R9", "loop releases pin", {tx_own, tx_oe}, 0);
    rx_src = 1'b1; wire_dir = 1'b1;
    @(negedge clk);
    chk(tx_own == 1'b1 && tx_oe == 1'b1, "R10", "single-wire output", {tx_own, tx_oe}, 3);
    wire_dir = 1'b0;
    @(negedge clk);
    chk(tx_own == 1'b1 && tx_oe == 1'b0, "R10", "single-wire input", {tx_own, tx_oe}, 2);
    loop_en = 1'b0;
    @(negedge clk);
    chk(tx_oe == 1'b1, "R10", "normal mode output", tx_oe, 1);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule